// File: doc/BRIEF.md
# Hoisted-Load Conflict Table

This block tracks loads that a compiler moved above earlier stores. When such a load issues early, it writes an entry that holds its destination register tag and the 8-byte line it read. Every later store probes the table with its own address, and any entry on the same line is dropped. The table keeps no separate violation flag: a store that overlaps the load simply removes the load's entry.

At the load's original place in the program, a check request looks the register tag up. If a live entry exists, the early value is still correct and is kept. If no entry exists, either because a store conflicted or because the entry was replaced, the response asks for the load to be executed again. A check always frees the entry it finds. The response arrives one cycle after the request.

Allocation works as follows. A new early load whose tag is already in the table reuses that entry. Otherwise it takes the lowest-numbered free entry. When the table is full, a rotating victim pointer selects the entry to replace. When an insert and a store meet in the same cycle, the insert is applied last, so the newer load survives.

Top module: `load_guard_table`

## Requirements
- R1: After reset the table is empty, so a check of any tag returns replay = 1, and `chk_rsp_valid` is 0 until the first check.
- R2: After an insert with tag T and address A, a check of T returns replay = 0, provided no store to A's line arrives in between.
- R3: A store whose address bits [ADDR_W-1:3] equal an entry's line removes that entry, whatever the low 3 address bits are. A later check of that tag returns replay = 1.
- R4: A store to a different line leaves every entry unchanged.
- R5: A check of a tag that has no entry returns replay = 1.
- R6: A check frees the entry it finds, so a second check of the same tag returns replay = 1.
- R7: An insert with a tag that is already present overwrites that entry's address. At most one live entry exists per tag, so a store to the old line no longer affects that tag.
- R8: An insert with a new tag takes the lowest-indexed free entry. When all ENTRIES entries are valid, it replaces the entry at the victim pointer. The pointer starts at 0 after reset and advances by one, wrapping, after each such replacement.
- R9: When an insert and a store to the same line occur in the same cycle, the inserted entry survives.
- R10: `chk_rsp_valid` is 1 exactly in the cycle after a cycle with `chk_valid` = 1. `chk_replay` is 0 whenever `chk_rsp_valid` is 0.
- R11: A check and an insert of the same tag in the same cycle answer from the table state before that cycle. The newly inserted entry remains afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | 1 | Early-load insert request |
| ins_tag | input | TAG_W | Destination register tag of the early load |
| ins_addr | input | ADDR_W | Address read by the early load |
| st_valid | input | 1 | Store probe request |
| st_addr | input | ADDR_W | Store address |
| chk_valid | input | 1 | Check request |
| chk_tag | input | TAG_W | Register tag to check |
| chk_rsp_valid | output | 1 | Check response valid, one cycle after the request |
| chk_replay | output | 1 | 1 = load must be executed again |

## Verification
The assertions check four properties on every cycle. The response appears exactly one cycle after a check and is silent otherwise. A tag never matches more than one live entry. A check that finds no entry is always answered with a replay. The victim pointer is used only when the table is full. The bench's scenarios are needed to show the rest against a reference model: line-granular store kills, overwrite on a repeated tag, lowest-free allocation, rotation of the victim pointer, and same-cycle ordering of insert, store and check. A long pseudo-random sweep over a few lines and tags compares every response with that model.

// File: rtl/load_guard_pkg.sv
// Package: shared types for the hoisted-load conflict table.
// Assumes: nothing beyond IEEE 1800-2017.
package load_guard_pkg;
    // Which rule selected the entry written by an insert.
    typedef enum logic [1:0] {
        PICK_NONE   = 2'd0,
        PICK_SAME   = 2'd1,
        PICK_FREE   = 2'd2,
        PICK_VICTIM = 2'd3
    } pick_e;
endpackage

// File: rtl/load_guard_cam.sv
// Module: parallel compare of one key against every entry.
// Output bit i is set when entry i is valid and its key equals the search key.
// Assumes: the caller gates the result with its own request valid.
module load_guard_cam #(
    parameter int N = 16,
    parameter int W = 5
) (
    input  logic [N-1:0]        ent_valid,
    input  logic [N-1:0][W-1:0] ent_key,
    input  logic [W-1:0]        key,
    output logic [N-1:0]        hit
);
    // One comparator per entry.
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit[i] = ent_valid[i] && (ent_key[i] == key);
    end
endmodule

// File: rtl/load_guard_alloc.sv
// Module: chooses the entry an insert writes, and owns the victim pointer.
// Order of choice: entry with the same tag, then the lowest free entry,
// then the entry at the rotating victim pointer.
// Assumes: same_hit has at most one bit set, and valid is the state before this cycle.
module load_guard_alloc
    import load_guard_pkg::*;
#(
    parameter int N     = 16,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_valid,
    input  logic [N-1:0]     valid,
    input  logic [N-1:0]     same_hit,
    output logic [IDX_W-1:0] ins_idx,
    output pick_e            pick
);
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] same_idx;
    logic [IDX_W-1:0] free_idx;
    logic             free_any;

    // Encode the index of the entry that already holds the tag.
    always_comb begin
        same_idx = '0;
        for (int i = 0; i < N; i++)
            if (same_hit[i]) same_idx = IDX_W'(i);
    end

    // Find the lowest-numbered free entry.
    always_comb begin
        free_idx = '0;
        free_any = 1'b0;
        for (int i = N - 1; i >= 0; i--)
            if (!valid[i]) begin
                free_idx = IDX_W'(i);
                free_any = 1'b1;
            end
    end

    // Choose the rule and the entry to write.
    always_comb begin
        if (!ins_valid) begin
            pick    = PICK_NONE;
            ins_idx = '0;
        end else if (|same_hit) begin
            pick    = PICK_SAME;
            ins_idx = same_idx;
        end else if (free_any) begin
            pick    = PICK_FREE;
            ins_idx = free_idx;
        end else begin
            pick    = PICK_VICTIM;
            ins_idx = rr_q;
        end
    end

    // Advance the victim pointer on each replacement, wrapping at N.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rr_q <= '0;
        else if (pick == PICK_VICTIM)
            rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
    end
endmodule

// File: rtl/load_guard_table.sv
// Module: table of early loads. Stores remove conflicting entries, and checks
// report whether an early load must be executed again.
// Assumes: updates in one cycle apply in this order: the check frees the entry
// it finds, the store kills every entry on its line, and the insert is written last.
// Lookups and allocation use the state from before the cycle.
module load_guard_table
    import load_guard_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 5,
    parameter int ADDR_W  = 32,
    parameter int LINE_LG = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic [TAG_W-1:0]  ins_tag,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              chk_valid,
    input  logic [TAG_W-1:0]  chk_tag,
    output logic              chk_rsp_valid,
    output logic              chk_replay
);
    localparam int LINE_W = ADDR_W - LINE_LG;
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0]             valid_q, valid_d;
    logic [ENTRIES-1:0][TAG_W-1:0]  tag_q;
    logic [ENTRIES-1:0][LINE_W-1:0] line_q;
    logic [ENTRIES-1:0]             chk_hit_w, ins_hit_w, st_hit_w;
    logic [IDX_W-1:0]               ins_idx_w;
    pick_e                          pick_w;

    load_guard_cam #(.N(ENTRIES), .W(TAG_W)) u_cam_chk (
        .ent_valid(valid_q), .ent_key(tag_q), .key(chk_tag), .hit(chk_hit_w));

    load_guard_cam #(.N(ENTRIES), .W(TAG_W)) u_cam_ins (
        .ent_valid(valid_q), .ent_key(tag_q), .key(ins_tag), .hit(ins_hit_w));

    load_guard_cam #(.N(ENTRIES), .W(LINE_W)) u_cam_st (
        .ent_valid(valid_q), .ent_key(line_q), .key(st_addr[ADDR_W-1:LINE_LG]),
        .hit(st_hit_w));

    load_guard_alloc #(.N(ENTRIES), .IDX_W(IDX_W)) u_alloc (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .valid(valid_q),
        .same_hit(ins_hit_w), .ins_idx(ins_idx_w), .pick(pick_w));

    // Next valid bits: check frees, store kills, insert sets last.
    always_comb begin
        valid_d = valid_q;
        if (chk_valid) valid_d = valid_d & ~chk_hit_w;
        if (st_valid)  valid_d = valid_d & ~st_hit_w;
        if (ins_valid) valid_d[ins_idx_w] = 1'b1;
    end

    // Entry storage: valid bits every cycle, tag and line on insert.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            tag_q   <= '0;
            line_q  <= '0;
        end else begin
            valid_q <= valid_d;
            if (ins_valid) begin
                tag_q[ins_idx_w]  <= ins_tag;
                line_q[ins_idx_w] <= ins_addr[ADDR_W-1:LINE_LG];
            end
        end
    end

    // Registered check response: replay when no live entry holds the tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_rsp_valid <= 1'b0;
            chk_replay    <= 1'b0;
        end else begin
            chk_rsp_valid <= chk_valid;
            chk_replay    <= chk_valid && !(|chk_hit_w);
        end
    end
endmodule

// File: rtl/load_guard_table_chk.sv
// Module: protocol and invariant checker for load_guard_table, attached by bind.
// Assumes: it sees the check hit vector, the valid bits and the allocation rule.
module load_guard_table_chk
    import load_guard_pkg::*;
#(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         chk_valid,
    input logic         chk_rsp_valid,
    input logic         chk_replay,
    input logic [N-1:0] chk_hit_w,
    input logic [N-1:0] valid_q,
    input pick_e        pick_w
);
    // R10: a response follows every check one cycle later.
    a_r10_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> chk_rsp_valid);

    // R10: no response without a check, and a quiet replay line.
    a_r10_rsp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> (!chk_rsp_valid && !chk_replay));

    // R7: at most one live entry matches any tag.
    a_r7_unique_tag: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chk_hit_w));

    // R5: a check that finds no entry is answered with a replay.
    a_r5_miss_replays: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && chk_hit_w == '0) |=> chk_replay);

    // R8: the victim pointer is used only when every entry is valid.
    a_r8_victim_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_w == PICK_VICTIM) |-> (&valid_q));
endmodule

bind load_guard_table load_guard_table_chk #(.N(ENTRIES)) u_chk (
    .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid),
    .chk_rsp_valid(chk_rsp_valid), .chk_replay(chk_replay),
    .chk_hit_w(chk_hit_w), .valid_q(valid_q), .pick_w(pick_w));

// File: tb/load_guard_table_tb_top.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus a long pseudo-random sweep, both checked
// against a behavioural model of the table built from the requirements.
module load_guard_table_tb_top;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_valid = 1'b0;
    logic [4:0]  ins_tag = '0;
    logic [31:0] ins_addr = '0;
    logic        st_valid = 1'b0;
    logic [31:0] st_addr = '0;
    logic        chk_valid = 1'b0;
    logic [4:0]  chk_tag = '0;
    logic        chk_rsp_valid;
    logic        chk_replay;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Behavioural model state.
    bit          m_v   [N];
    int          m_tag [N];
    logic [28:0] m_line[N];
    int          m_rr;

    always #4 clk = ~clk;

    load_guard_table dut_i (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_tag(ins_tag), .ins_addr(ins_addr),
        .st_valid(st_valid), .st_addr(st_addr),
        .chk_valid(chk_valid), .chk_tag(chk_tag),
        .chk_rsp_valid(chk_rsp_valid), .chk_replay(chk_replay));

    task automatic check(bit ok, string req, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle of stimulus, entered and left at a falling edge.
    // exp: -1 uses the model, 0/1 is a directed expected replay.
    task automatic step(bit iv, int it, logic [31:0] ia, bit sv, logic [31:0] sa,
                        bit cv, int ct, int exp, string req);
        int hit = -1, same = -1, fre = -1, tgt, e;
        bit vic = 0;
        ins_valid = iv; ins_tag = 5'(it); ins_addr = ia;
        st_valid = sv; st_addr = sa; chk_valid = cv; chk_tag = 5'(ct);
        for (int i = 0; i < N; i++) begin
            if (m_v[i] && m_tag[i] == ct) hit = i;
            if (m_v[i] && m_tag[i] == it) same = i;
        end
        for (int i = N - 1; i >= 0; i--) if (!m_v[i]) fre = i;
        if (same >= 0) tgt = same;
        else if (fre >= 0) tgt = fre;
        else begin tgt = m_rr; vic = 1; end
        @(negedge clk);
        if (cv) begin
            e = (exp >= 0) ? exp : int'(hit < 0);
            check(chk_rsp_valid == 1'b1, "R10 rsp_valid", int'(chk_rsp_valid), 1);
            check(int'(chk_replay) == e, req, int'(chk_replay), e);
        end else begin
            check(!chk_rsp_valid && !chk_replay, "R10 idle", int'(chk_rsp_valid), 0);
        end
        if (cv && hit >= 0) m_v[hit] = 0;
        if (sv) for (int i = 0; i < N; i++)
            if (m_v[i] && m_line[i] == sa[31:3]) m_v[i] = 0;
        if (iv) begin
            m_v[tgt] = 1; m_tag[tgt] = it; m_line[tgt] = ia[31:3];
            if (vic) m_rr = (m_rr + 1) % N;
        end
        ins_valid = 0; st_valid = 0; chk_valid = 0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < N; i++) m_v[i] = 0;
        m_rr = 0;
    endtask

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        @(negedge clk);
        do_reset();
        check(!chk_rsp_valid && !chk_replay, "R1 reset outputs", int'(chk_rsp_valid), 0);
        step(0,0,0, 0,0, 1,3, 1, "R1 empty after reset");

        // R2 / R6: insert, check hits, second check replays.
        step(1,4,32'h100, 0,0, 0,0, -1, "R2");
        step(0,0,0, 0,0, 1,4, 0, "R2 hit keeps value");
        step(0,0,0, 0,0, 1,4, 1, "R6 freed by check");

        // R3: store on same line, different low bits.
        step(1,5,32'h200, 0,0, 0,0, -1, "R3");
        step(0,0,0, 1,32'h205, 0,0, -1, "R3");
        step(0,0,0, 0,0, 1,5, 1, "R3 store kills entry");

        // R4: store to a neighbouring line.
        step(1,6,32'h300, 0,0, 0,0, -1, "R4");
        step(0,0,0, 1,32'h308, 0,0, -1, "R4");
        step(0,0,0, 0,0, 1,6, 0, "R4 other line no effect");

        // R5: unknown tag.
        step(0,0,0, 0,0, 1,31, 1, "R5 missing replays");

        // R7: overwrite with a new line, store to old line.
        step(1,7,32'h400, 0,0, 0,0, -1, "R7");
        step(1,7,32'h500, 0,0, 0,0, -1, "R7");
        step(0,0,0, 1,32'h400, 0,0, -1, "R7");
        step(0,0,0, 0,0, 1,7, 0, "R7 overwrite moved line");

        // R9: insert and store to the same line together.
        step(1,8,32'h600, 1,32'h600, 0,0, -1, "R9");
        step(0,0,0, 0,0, 1,8, 0, "R9 insert survives store");

        // R11: check and insert of same tag together.
        step(1,9,32'h700, 1,32'h600, 1,9, 1, "R11 pre-state answer");
        step(0,0,0, 0,0, 1,9, 0, "R11 inserted entry stays");

        // R8: fill, then two replacements hit entries 0 and 1.
        do_reset();
        for (int t = 0; t < N; t++) step(1,t,32'h1000 + 32'(t*8), 0,0, 0,0, -1, "R8");
        step(1,16,32'h2000, 0,0, 0,0, -1, "R8");
        step(1,17,32'h2008, 0,0, 0,0, -1, "R8");
        step(0,0,0, 0,0, 1,0, 1, "R8 victim 0 replaced");
        step(0,0,0, 0,0, 1,1, 1, "R8 victim 1 replaced");
        step(0,0,0, 0,0, 1,2, 0, "R8 entry 2 untouched");
        step(1,18,32'h2010, 0,0, 0,0, -1, "R8");
        step(0,0,0, 0,0, 1,18, 0, "R8 lowest free reused");

        // Sweep: four lines, tags mostly 0..7, all operations mixed.
        do_reset();
        for (int k = 0; k < 4000; k++) begin
            bit iv, sv, cv;
            int it, ct;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            iv = lfsr[0]; sv = lfsr[1] & lfsr[2]; cv = lfsr[3];
            it = lfsr[4] ? int'(lfsr[7:5]) : int'(lfsr[12:8]);
            ct = lfsr[13] ? int'(lfsr[10:8]) : int'(lfsr[15:11]);
            step(iv, it, {27'd0, lfsr[6:5], lfsr[2:0]}, sv,
                 {27'd0, lfsr[9:8], lfsr[14:12]}, cv, ct, -1, "R2 R3 sweep");
        end
        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (200000) @(posedge clk);
                check(1'b0, "watchdog expired", 0, 1);
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule